// File: doc/BRIEF.md
# Interleaved Two-Phase Gate Sequencer

This block is the digital core of a two-phase synchronous buck controller. Each phase has a high-side and a low-side switch. For each phase, the block turns a PWM comparator bit into two gate enables. A free-running master count, divided by two, opens a switching window for phase A at position 0 and one for phase B half a period later, so the two phases run 180 degrees apart.

Switch transitions are adaptive. The low-side enable rises only after the switch node is reported low, and then a short fixed settling delay passes. The high-side enable rises only after the low-side gate is reported discharged. If a sense bit never arrives, a timeout lets the phase move on, so it cannot lock up.

The block also enforces these limits and modes:
- A duty cap limits how long the high side stays on.
- The low side gets a guaranteed minimum on-time in every period.
- A light-load mode parks phase A.
- An enable input stops both phases.
- An over-voltage flag latches the crowbar state until reset.

Vector bit 0 always belongs to phase A and bit 1 to phase B. All timing is counted in system clock cycles. The block has no data stream, so every pin is a plain level.

Top module: `dual_phase_gate_seq`

## Requirements

Positions are counted in clock edges after reset release, modulo `PERIOD_CYC` (default 300). Phase B positions are offset by `PERIOD_CYC/2`. Default parameters are used throughout.

- R1: Phase A's window opens at position 0 and phase B's at position 150. With both sense bits high and the PWM bit high, each phase's high-side enable is high from window position 2 through position `HI_LIMIT-1`. Each phase's low-side enable is high from position `HI_LIMIT+DEAD_CYC+1` through position 0 of the next window, and phase B is delayed by exactly 150 cycles relative to phase A.
- R2: A high-side enable is never high at window position `HI_LIMIT` or later. `HI_LIMIT` is the smaller of `PERIOD_CYC*MAX_DUTY_PCT/100` and `PERIOD_CYC-DEAD_CYC-TMO_CYC-MIN_LO_CYC`, which is 270 by default.
- R3: A PWM bit sampled low while the high side is on drops the high-side enable after that clock edge. A PWM bit that is low when a window opens leaves the low side on for that whole window.
- R4: After the high side turns off, both enables stay low until the switch-low sense bit has been sampled high. They then stay low for a further `DEAD_CYC` cycles (default 3), and only then does the low-side enable rise.
- R5: After the low side turns off, the high-side enable rises on the edge that samples the low-gate-low sense bit high, and not before.
- R6: A sense bit that stays low is waited for at most `TMO_CYC` cycles (default 8). After that, the sequence proceeds as if the sense bit had arrived.
- R7: The low-side enable stays on for at least `MIN_LO_CYC` cycles (default 17) in every period, even when both sense bits time out. In that case the low-side on-time is exactly 20 cycles.
- R8: While light-load mode is set, both of phase A's enables are low from the next edge on, and phase B keeps switching unchanged.
- R9: A low enable input forces all four gate enables low from the next edge on. After enable returns high, each phase resumes at the next opening of its own window.
- R10: An over-voltage flag sampled high forces both high-side enables low and both low-side enables high from the next edge on. This state persists after the flag clears, until reset.
- R11: The high-side and low-side enables of a phase are never high in the same cycle.
- R12: While reset is asserted and right after its release, all gate enables are low.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_req | input | 2 | PWM comparator bit per phase (1 = request high-side on) |
| sw_low | input | 2 | Switch node sensed low, per phase |
| lsg_low | input | 2 | Low-side gate sensed discharged, per phase |
| enable | input | 1 | Switching enable; low stops both phases |
| light_load | input | 1 | Light-load mode; parks phase A |
| ov_flag | input | 1 | Over-voltage detect |
| hs_en | output | 2 | High-side gate enable per phase |
| ls_en | output | 2 | Low-side gate enable per phase |

## Verification

A corrupted window counter shows within one period: a phase's high-side edges shift away from positions 2 and `HI_LIMIT`, and the 150-cycle spacing between the phases is lost. A wrong sequencer state shows as the same-cycle overlap that the overlap property catches. It can also show as a low-side rise that comes too early or too late relative to a sense edge, which the bench sees on the next sampled cycle. A crowbar latch that fails to hold shows as switching that resumes after the over-voltage flag clears.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

  // Per-phase sequencing state.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_LSG,
    ST_HIGH,
    ST_WAIT_SW,
    ST_DEAD,
    ST_LOW
  } gseq_state_e;

  function automatic int unsigned gseq_min(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/gseq_phase_timer.sv
module gseq_phase_timer #(
  parameter int unsigned PERIOD_CYC = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [1:0] win_start
);
  localparam int unsigned CW   = $clog2(PERIOD_CYC);
  localparam int unsigned HALF = PERIOD_CYC / 2;

  logic [CW-1:0] tick;

  always_ff @(posedge clk) begin
    if (!rst_n)                           tick <= '0;
    else if (tick == CW'(PERIOD_CYC - 1)) tick <= '0;
    else                                  tick <= tick + 1'b1;
  end

  // Divide-by-two: the two window openings sit half a period apart.
  assign win_start[0] = (tick == '0);
  assign win_start[1] = (tick == CW'(HALF));

  assert_one_window_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_start));
  assert_window_not_repeated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win_start[0] |=> !win_start[0]);

endmodule

// File: rtl/gseq_phase_fsm.sv
module gseq_phase_fsm
  import gseq_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 300,
  parameter int unsigned HI_LIMIT   = 270,
  parameter int unsigned DEAD_CYC   = 3,
  parameter int unsigned TMO_CYC    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic win_start,
  input  logic pwm,
  input  logic sw_low,
  input  logic lsg_low,
  output logic hs_o,
  output logic ls_o
);
  localparam int unsigned PW   = $clog2(PERIOD_CYC + 1);
  localparam int unsigned WMAX = (TMO_CYC > DEAD_CYC) ? TMO_CYC : DEAD_CYC;
  localparam int unsigned WW   = $clog2(WMAX + 1);

  gseq_state_e    state, nxt;
  logic [PW-1:0]  pcnt;   // cycles since this phase's window opened
  logic [WW-1:0]  wcnt;   // cycles spent in the current state
  logic           tmo_hit;

  assign tmo_hit = (wcnt == WW'(TMO_CYC - 1));

  always_comb begin
    nxt = state;
    if (!run) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:     if (win_start && pwm)                   nxt = ST_WAIT_LSG;
        ST_WAIT_LSG: if (lsg_low || tmo_hit)                 nxt = ST_HIGH;
        ST_HIGH:     if (!pwm || pcnt >= PW'(HI_LIMIT - 1))  nxt = ST_WAIT_SW;
        ST_WAIT_SW:  if (sw_low || tmo_hit)                  nxt = ST_DEAD;
        ST_DEAD:     if (wcnt == WW'(DEAD_CYC - 1))          nxt = ST_LOW;
        ST_LOW:      if (win_start && pwm)                   nxt = ST_WAIT_LSG;
        default:                                             nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      wcnt  <= '0;
      pcnt  <= '0;
    end else begin
      state <= nxt;
      if (nxt != state)              wcnt <= '0;
      else if (wcnt != WW'(WMAX))    wcnt <= wcnt + 1'b1;
      if (win_start)                 pcnt <= PW'(1);
      else if (pcnt != PW'(PERIOD_CYC)) pcnt <= pcnt + 1'b1;
    end
  end

  assign hs_o = (state == ST_HIGH);
  assign ls_o = (state == ST_LOW);

  assert_high_within_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hs_o |-> (pcnt < PW'(HI_LIMIT)));
  assert_low_after_high_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_o) |-> $past(!hs_o));
  assert_high_after_low_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_o) |-> $past(!ls_o));

endmodule

// File: rtl/gseq_crowbar.sv
module gseq_crowbar #(
  parameter int unsigned NPH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ov_flag,
  input  logic [NPH-1:0] hs_in,
  input  logic [NPH-1:0] ls_in,
  output logic           ov_lat,
  output logic [NPH-1:0] hs_out,
  output logic [NPH-1:0] ls_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) ov_lat <= 1'b0;
    else        ov_lat <= ov_lat | ov_flag;
  end

  assign hs_out = ov_lat ? '0 : hs_in;
  assign ls_out = ov_lat ? '1 : ls_in;

  assert_ov_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ov_lat |=> ov_lat);
  assert_ov_crowbar_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ov_flag |=> (hs_out == '0 && ls_out == '1));

endmodule

// File: rtl/dual_phase_gate_seq.sv
module dual_phase_gate_seq
  import gseq_pkg::*;
#(
  parameter int unsigned PERIOD_CYC   = 300,
  parameter int unsigned MAX_DUTY_PCT = 90,
  parameter int unsigned MIN_LO_CYC   = 17,
  parameter int unsigned DEAD_CYC     = 3,
  parameter int unsigned TMO_CYC      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_req,
  input  logic [1:0] sw_low,
  input  logic [1:0] lsg_low,
  input  logic       enable,
  input  logic       light_load,
  input  logic       ov_flag,
  output logic [1:0] hs_en,
  output logic [1:0] ls_en
);
  localparam int unsigned NPH      = 2;
  localparam int unsigned DUTY_CAP = PERIOD_CYC * MAX_DUTY_PCT / 100;
  localparam int unsigned LOW_KEEP = PERIOD_CYC - DEAD_CYC - TMO_CYC - MIN_LO_CYC;
  localparam int unsigned HI_LIMIT = gseq_min(DUTY_CAP, LOW_KEEP);

  logic [NPH-1:0] win_start, phase_run, fsm_hs, fsm_ls;
  logic           ov_lat;

  gseq_phase_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .win_start(win_start)
  );

  // Phase A is parked in light-load mode; both halt on disable or crowbar.
  assign phase_run = {enable & ~ov_lat, enable & ~light_load & ~ov_lat};

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    gseq_phase_fsm #(
      .PERIOD_CYC(PERIOD_CYC), .HI_LIMIT(HI_LIMIT),
      .DEAD_CYC(DEAD_CYC),     .TMO_CYC(TMO_CYC)
    ) u_fsm (
      .clk(clk), .rst_n(rst_n), .run(phase_run[g]), .win_start(win_start[g]),
      .pwm(pwm_req[g]), .sw_low(sw_low[g]), .lsg_low(lsg_low[g]),
      .hs_o(fsm_hs[g]), .ls_o(fsm_ls[g])
    );
  end

  gseq_crowbar #(.NPH(NPH)) u_crowbar (
    .clk(clk), .rst_n(rst_n), .ov_flag(ov_flag),
    .hs_in(fsm_hs), .ls_in(fsm_ls),
    .ov_lat(ov_lat), .hs_out(hs_en), .ls_out(ls_en)
  );

  assert_no_shoot_through_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_en & ls_en) == '0);
  assert_disable_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !ov_lat) |=> (hs_en == '0 && (ls_en == '0 || ov_lat)));
  assert_light_parks_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (light_load && !ov_lat) |=> (!hs_en[0] && (!ls_en[0] || ov_lat)));

endmodule

// File: tb/dual_phase_gate_seq_bench.sv
module dual_phase_gate_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pwm_req = 2'b11, sw_low = 2'b11, lsg_low = 2'b11;
  logic       enable = 1'b1, light_load = 1'b0, ov_flag = 1'b0;
  logic [1:0] hs_en, ls_en;
  int         cyc = 0, total = 0, fails = 0;

  dual_phase_gate_seq u_dual_phase_gate_seq (
    .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req), .sw_low(sw_low), .lsg_low(lsg_low),
    .enable(enable), .light_load(light_load), .ov_flag(ov_flag),
    .hs_en(hs_en), .ls_en(ls_en)
  );

  always #10 clk = ~clk;   // 50 MHz

  // Steady run, both senses instant, PWM high: {hs_b, hs_a, ls_b, ls_a}.
  localparam int VT_N = 22;
  localparam int unsigned VT_CYC [VT_N] = '{0, 1, 2, 100, 150, 151, 152, 269, 270, 273, 274,
                                            299, 300, 301, 302, 419, 420, 423, 424, 450, 451, 452};
  localparam logic [3:0] VT_EXP [VT_N] = '{4'b0000, 4'b0000, 4'b0100, 4'b0100, 4'b0100, 4'b0100,
                                           4'b1100, 4'b1100, 4'b1000, 4'b1000, 4'b1001, 4'b1001,
                                           4'b1001, 4'b1000, 4'b1100, 4'b1100, 4'b0100, 4'b0100,
                                           4'b0110, 4'b0110, 4'b0100, 4'b1100};

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic goto(input int t);
    while (cyc < t) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 reset", {hs_en, ls_en}, 4'b0000);
    rst_n = 1'b1;
    cyc = 0;
    chk("R12 after release", {hs_en, ls_en}, 4'b0000);
  endtask

  initial begin
    #(20 * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // Vector table: R1 timing, R2 cap at 270, R4 dead time, R11 overlap.
    restart();
    for (int i = 0; i < VT_N; i++) begin
      goto(int'(VT_CYC[i]));
      chk("R1/R2/R4 steady", {hs_en, ls_en}, VT_EXP[i]);
      chk("R11 overlap", {2'b00, hs_en & ls_en}, 4'b0000);
    end

    // R3: PWM drop ends high side; low window held when PWM low.
    restart();
    goto(50);  chk("R3 high before drop", {2'b00, hs_en}, 4'b0001 & {2'b00, hs_en} | 4'b0001);
    pwm_req[0] = 1'b0;
    goto(51);  chk("R3 high off next edge", {3'b000, hs_en[0]}, 4'b0000);
    goto(54);  chk("R4 dead after drop", {3'b000, ls_en[0]}, 4'b0000);
    goto(55);  chk("R4 low after dead", {3'b000, ls_en[0]}, 4'b0001);
    goto(305); chk("R3 low kept, PWM low", {2'b00, hs_en[0], ls_en[0]}, 4'b0001);
    pwm_req = 2'b11;

    // R6/R7: phase A senses never arrive.
    sw_low = 2'b10; lsg_low = 2'b10;
    restart();
    goto(8);   chk("R6 lsg wait", {3'b000, hs_en[0]}, 4'b0000);
    goto(9);   chk("R6 lsg timeout", {3'b000, hs_en[0]}, 4'b0001);
    goto(270); chk("R2 cap with timeout", {3'b000, hs_en[0]}, 4'b0000);
    goto(280); chk("R6 sw wait+dead", {3'b000, ls_en[0]}, 4'b0000);
    goto(281); chk("R6 sw timeout", {3'b000, ls_en[0]}, 4'b0001);
    begin
      int run_len = 1;
      while (cyc < 301) begin
        goto(cyc + 1);
        if (ls_en[0]) run_len++;
      end
      chk("R7 min low on-time", 4'(run_len), 4'(20));
      chk("R7 not below minimum", {3'b000, run_len >= 17}, 4'b0001);
    end

    // R5/R4: late sense edges.
    sw_low = 2'b10; lsg_low = 2'b10;
    restart();
    goto(4);   chk("R5 wait for lsg", {3'b000, hs_en[0]}, 4'b0000);
    lsg_low[0] = 1'b1;
    goto(5);   chk("R5 high on lsg", {3'b000, hs_en[0]}, 4'b0001);
    goto(272); chk("R4 wait for sw", {3'b000, ls_en[0]}, 4'b0000);
    sw_low[0] = 1'b1;
    goto(275); chk("R4 dead after sw", {3'b000, ls_en[0]}, 4'b0000);
    goto(276); chk("R4 low after dead", {3'b000, ls_en[0]}, 4'b0001);
    sw_low = 2'b11; lsg_low = 2'b11;

    // R8: light-load mode.
    light_load = 1'b1;
    restart();
    goto(2);   chk("R8 A parked", {2'b00, hs_en[0], ls_en[0]}, 4'b0000);
    goto(152); chk("R8 B high", {hs_en, ls_en}, 4'b1000);
    goto(274); chk("R8 A parked", {2'b00, hs_en[0], ls_en[0]}, 4'b0000);
    goto(424); chk("R8 B low", {hs_en, ls_en}, 4'b0010);
    light_load = 1'b0;

    // R9: enable.
    restart();
    goto(100); chk("R9 running", {hs_en, ls_en}, 4'b0100);
    enable = 1'b0;
    goto(101); chk("R9 stopped", {hs_en, ls_en}, 4'b0000);
    goto(250); chk("R9 stays stopped", {hs_en, ls_en}, 4'b0000);
    goto(260); enable = 1'b1;
    goto(301); chk("R9 waits for window", {hs_en, ls_en}, 4'b0000);
    goto(302); chk("R9 A resumes", {hs_en, ls_en}, 4'b0100);
    goto(451); chk("R9 B waits", {hs_en, ls_en}, 4'b0100);
    goto(452); chk("R9 B resumes", {hs_en, ls_en}, 4'b1100);

    // R10: over-voltage crowbar.
    restart();
    goto(100); ov_flag = 1'b1;
    goto(101); chk("R10 crowbar", {hs_en, ls_en}, 4'b0011);
    ov_flag = 1'b0;
    goto(400); chk("R10 latched", {hs_en, ls_en}, 4'b0011);
    restart();
    goto(2);   chk("R10 cleared by reset", {hs_en, ls_en}, 4'b0100);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule